// File: doc/BRIEF.md
# Quadword Rotate, Mask and Insert Unit

This unit rotates a 128-bit source value left by a variable amount and then uses the result in one of three ways. It can return the rotated value as it is. It can AND it with a generated bit mask. It can also merge it into an existing destination value under that mask, so that destination bits outside the mask are kept. A single mask generator serves both mask operations. The rotate amount, the mask begin index and the mask end index all come from one control operand.

The unit is a combinational datapath. When the `REG_OUT` parameter is 1 (the default), a result register follows the datapath and the result appears one clock after the operands. A vector execution pipe drives the three operands and a 2-bit operation code, then writes `result` back to its register file.

Top module: `qrot_mask_unit`

## Requirements
- R1: With `REG_OUT`=1, a synchronous active-high `rst` clears `result` to zero. Outside reset, `result` shows the operation on the operands sampled at the previous rising edge of `clk`.
- R2: `op_sel` encodes the operation. 2'b00 is plain rotate, 2'b01 is rotate-and-mask, 2'b10 is rotate-and-insert, and 2'b11 behaves exactly like plain rotate.
- R3: The rotation is a left rotation of all 128 bits of `src_a` by `ctrl_b[6:0]` (0 to 127). Bits leaving bit 127 re-enter at bit 0.
- R4: In plain rotate, `dest_t` and every bit of `ctrl_b` outside [6:0] have no effect on `result`.
- R5: The mask end index is `ctrl_b[14:8]` and the mask begin index is `ctrl_b[22:16]`. Mask index i refers to result bit 127-i, so index 0 is the most significant bit.
- R6: When begin <= end, the mask is one for indices begin through end inclusive and zero elsewhere. Begin equal to end gives a single one bit.
- R7: When begin > end, the mask wraps. It is one for indices begin through 127 and 0 through end, and zero for indices strictly between end and begin.
- R8: In rotate-and-mask, `result` is the rotated value AND the mask, and `dest_t` has no effect.
- R9: In rotate-and-insert, `result` is (rotated value AND mask) OR (`dest_t` AND NOT mask).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 2 | Operation code |
| src_a | input | 128 | Value to rotate |
| ctrl_b | input | 128 | Control operand: rotate amount, mask end, mask begin |
| dest_t | input | 128 | Current destination value for insert |
| result | output | 128 | Operation result |

## Verification
The bench checks rotate amounts 0 and 127. A rotator that mishandles the doubled shift would return a zero or a one-bit-off value at those ends. Masks with begin equal to end, with begin 0 and end 127, and with begin past end are compared against a per-index reference. A generator with the bit order reversed, or a wrap handled as an empty mask, would show up there as misplaced or missing ones. Plain rotate is driven with garbage in `dest_t` and in the upper bits of `ctrl_b`, so a unit that leaked either into its output would miscompare. Insert is run with zero and all-ones destinations, and with a source of zero, to expose a merge that inverts the mask or drops the kept destination bits.

// File: rtl/qrot_pkg.sv
package qrot_pkg;

    typedef enum logic [1:0] {
        QOP_ROT  = 2'b00,
        QOP_MASK = 2'b01,
        QOP_INS  = 2'b10,
        QOP_RSV  = 2'b11
    } qop_e;

    // Bit offsets of the control fields inside the control operand
    localparam int unsigned FLD_AMT_LSB = 0;
    localparam int unsigned FLD_END_LSB = 8;
    localparam int unsigned FLD_BEG_LSB = 16;

    localparam int unsigned CTL_IDX_W = 7;

    typedef struct packed {
        logic [CTL_IDX_W-1:0] amt;
        logic [CTL_IDX_W-1:0] mbeg;
        logic [CTL_IDX_W-1:0] mend;
    } qctl_t;

    function automatic qctl_t unpack_ctl(input logic [63:0] dw);
        qctl_t c;
        c.amt  = dw[FLD_AMT_LSB +: CTL_IDX_W];
        c.mend = dw[FLD_END_LSB +: CTL_IDX_W];
        c.mbeg = dw[FLD_BEG_LSB +: CTL_IDX_W];
        return c;
    endfunction

    function automatic qop_e to_op(input logic [1:0] code);
        return qop_e'(code);
    endfunction

endpackage

// File: rtl/qrot_rotl.sv
module qrot_rotl #(
    parameter int unsigned W = 128,
    localparam int unsigned IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     din,
    input  logic [IDX_W-1:0] amt,
    output logic [W-1:0]     dout
);
    logic [2*W-1:0] dbl;

    always_comb begin
        dbl  = {din, din} << amt;
        dout = dbl[2*W-1:W];
    end
endmodule

// File: rtl/qrot_maskgen.sv
module qrot_maskgen #(
    parameter int unsigned W = 128,
    localparam int unsigned IDX_W = $clog2(W)
) (
    input  logic [IDX_W-1:0] mbeg,
    input  logic [IDX_W-1:0] mend,
    output logic [W-1:0]     mask
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(W - 1);

    logic [W-1:0]     from_beg;
    logic [W-1:0]     upto_end;
    logic [IDX_W-1:0] end_shift;

    always_comb begin
        // index 0 is the MSB: indices >= mbeg are the low W-mbeg bits
        from_beg  = {W{1'b1}} >> mbeg;
        end_shift = TOP_IDX - mend;
        upto_end  = {W{1'b1}} << end_shift;
        if (mbeg <= mend) begin
            mask = from_beg & upto_end;
        end else begin
            mask = from_beg | upto_end;
        end
    end
endmodule

// File: rtl/qrot_merge.sv
module qrot_merge #(
    parameter int unsigned W = 128
) (
    input  qrot_pkg::qop_e op,
    input  logic [W-1:0]   rot,
    input  logic [W-1:0]   mask,
    input  logic [W-1:0]   dest,
    output logic [W-1:0]   res
);
    import qrot_pkg::*;

    always_comb begin
        unique case (op)
            QOP_MASK: res = rot & mask;
            QOP_INS:  res = (rot & mask) | (dest & ~mask);
            default:  res = rot;
        endcase
    end
endmodule

// File: rtl/qrot_mask_unit.sv
module qrot_mask_unit #(
    parameter int unsigned DATA_W  = 128,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] ctrl_b,
    input  logic [DATA_W-1:0] dest_t,
    output logic [DATA_W-1:0] result
);
    import qrot_pkg::*;

    localparam int unsigned IDX_W = $clog2(DATA_W);

    qctl_t            ctl;
    qop_e             op;
    logic [DATA_W-1:0] rot_val;
    logic [DATA_W-1:0] mask_val;
    logic [DATA_W-1:0] comb_res;

    always_comb begin
        ctl = unpack_ctl(ctrl_b[63:0]);
        op  = to_op(op_sel);
    end

    qrot_rotl #(.W(DATA_W)) u_rotl (
        .din  (src_a),
        .amt  (IDX_W'(ctl.amt)),
        .dout (rot_val)
    );

    qrot_maskgen #(.W(DATA_W)) u_maskgen (
        .mbeg (IDX_W'(ctl.mbeg)),
        .mend (IDX_W'(ctl.mend)),
        .mask (mask_val)
    );

    qrot_merge #(.W(DATA_W)) u_merge (
        .op   (op),
        .rot  (rot_val),
        .mask (mask_val),
        .dest (dest_t),
        .res  (comb_res)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    result <= '0;
                end else begin
                    result <= comb_res;
                end
            end
        end else begin : g_comb
            assign result = comb_res;
        end
    endgenerate
endmodule

// File: rtl/qrot_mask_unit_chk.sv
module qrot_mask_unit_chk #(
    parameter int unsigned DATA_W  = 128,
    parameter bit          REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        op_sel,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] ctrl_b,
    input logic [DATA_W-1:0] dest_t,
    input logic [DATA_W-1:0] result
);
    generate
        if (REG_OUT) begin : g_chk
            assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> result == '0);

            assert_rot_ones_R3: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && ($past(op_sel) == 2'b00 || $past(op_sel) == 2'b11))
                |-> $countones(result) == $countones($past(src_a)));

            assert_rot_zero_R3: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(op_sel) == 2'b00 && $past(ctrl_b[6:0]) == 7'd0)
                |-> result == $past(src_a));

            assert_single_bit_R6: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(op_sel) == 2'b01 &&
                 $past(ctrl_b[14:8]) == $past(ctrl_b[22:16]))
                |-> $countones(result) <= 1);

            assert_mask_subset_R8: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(op_sel) == 2'b01)
                |-> $countones(result) <= $countones($past(src_a)));

            assert_insert_keep_R9: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(op_sel) == 2'b10 && $past(src_a) == '0)
                |-> (result & ~$past(dest_t)) == '0);
        end
    endgenerate
endmodule

bind qrot_mask_unit qrot_mask_unit_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .op_sel (op_sel),
    .src_a  (src_a),
    .ctrl_b (ctrl_b),
    .dest_t (dest_t),
    .result (result)
);

// File: tb/qrot_mask_unit_bench.sv
module qrot_mask_unit_bench;
    localparam int W = 128;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   op_sel = 2'b00;
    logic [W-1:0] src_a = '0;
    logic [W-1:0] ctrl_b = '0;
    logic [W-1:0] dest_t = '0;
    logic [W-1:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    qrot_mask_unit u_qrot_mask_unit (
        .clk(clk), .rst(rst), .op_sel(op_sel),
        .src_a(src_a), .ctrl_b(ctrl_b), .dest_t(dest_t), .result(result)
    );

    function automatic logic [W-1:0] ref_rot(input logic [W-1:0] a, input int n);
        logic [W-1:0] r;
        for (int j = 0; j < W; j++) r[(j + n) % W] = a[j];
        return r;
    endfunction

    function automatic logic [W-1:0] ref_mask(input int b, input int e);
        logic [W-1:0] m;
        for (int i = 0; i < W; i++)
            m[W-1-i] = (b <= e) ? (i >= b && i <= e) : (i >= b || i <= e);
        return m;
    endfunction

    function automatic logic [W-1:0] mk_ctl(input int amt, input int b, input int e);
        logic [W-1:0] c = '0;
        c[6:0]   = 7'(amt);
        c[14:8]  = 7'(e);
        c[22:16] = 7'(b);
        return c;
    endfunction

    function automatic logic [W-1:0] ref_op(input logic [1:0] op, input logic [W-1:0] a,
                                            input logic [W-1:0] c, input logic [W-1:0] t);
        logic [W-1:0] r = ref_rot(a, int'(c[6:0]));
        logic [W-1:0] m = ref_mask(int'(c[22:16]), int'(c[14:8]));
        case (op)
            2'b01:   return r & m;
            2'b10:   return (r & m) | (t & ~m);
            default: return r;
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [1:0] op, input logic [W-1:0] a,
                          input logic [W-1:0] c, input logic [W-1:0] t,
                          input logic [W-1:0] exp);
        @(negedge clk);
        op_sel = op; src_a = a; ctrl_b = c; dest_t = t;
        @(negedge clk);
        check(req, result, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        op_sel = 2'b10; src_a = '1; dest_t = '1; ctrl_b = mk_ctl(3, 0, 127);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset value", result, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 latency after reset", result, '1);
    endtask

    task automatic t_rotate;
        logic [W-1:0] a = {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 32'hC0FFEE11};
        run_op("R3 amount 0", 2'b00, a, mk_ctl(0, 5, 9), '0, a);
        run_op("R3 amount 1", 2'b00, {1'b1, {(W-1){1'b0}}}, mk_ctl(1, 0, 0), '0, {{(W-1){1'b0}}, 1'b1});
        run_op("R3 amount 127", 2'b00, a, mk_ctl(127, 0, 0), '0, {a[0], a[W-1:1]});
        run_op("R3 amount 64", 2'b00, a, mk_ctl(64, 0, 0), '0, {a[63:0], a[127:64]});
        run_op("R2 code 11 rotates", 2'b11, a, mk_ctl(13, 2, 7), '1, ref_rot(a, 13));
    endtask

    task automatic t_ignore;
        logic [W-1:0] a = {4{32'h5A3C_96E1}};
        logic [W-1:0] c = {{(W-7){1'b1}}, 7'd9};
        run_op("R4 upper control and dest ignored", 2'b00, a, c, {4{32'hF0F0_1234}}, ref_rot(a, 9));
        run_op("R8 dest ignored in mask mode", 2'b01, '1, mk_ctl(0, 10, 20), '1,
               ref_mask(10, 20));
    endtask

    task automatic t_mask_contig;
        run_op("R5 index 0 is msb", 2'b01, '1, mk_ctl(0, 0, 0), '0, {1'b1, {(W-1){1'b0}}});
        run_op("R6 begin equals end", 2'b01, '1, mk_ctl(0, 100, 100), '0,
               {{100{1'b0}}, 1'b1, {27{1'b0}}});
        run_op("R6 full mask 0..127", 2'b01, '1, mk_ctl(0, 0, 127), '0, '1);
        run_op("R6 low bit only", 2'b01, '1, mk_ctl(0, 127, 127), '0, {{(W-1){1'b0}}, 1'b1});
        run_op("R6 range 8..15", 2'b01, '1, mk_ctl(0, 8, 15), '0, {8'h00, 8'hFF, {112{1'b0}}});
    endtask

    task automatic t_mask_wrap;
        run_op("R7 wrap 120..7", 2'b01, '1, mk_ctl(0, 120, 7), '0,
               {8'hFF, {112{1'b0}}, 8'hFF});
        run_op("R7 wrap 127..0", 2'b01, '1, mk_ctl(0, 127, 0), '0,
               {1'b1, {(W-2){1'b0}}, 1'b1});
        run_op("R7 wrap 1..0 gap of none", 2'b01, '1, mk_ctl(0, 1, 0), '0, '1);
        run_op("R8 rotate then mask", 2'b01, {{(W-4){1'b0}}, 4'hF}, mk_ctl(124, 0, 3), '0,
               {4'hF, {(W-4){1'b0}}});
    endtask

    task automatic t_insert;
        run_op("R9 insert into zero", 2'b10, '1, mk_ctl(5, 4, 11), '0, ref_mask(4, 11));
        run_op("R9 insert keeps dest", 2'b10, '0, mk_ctl(5, 4, 11), '1, ~ref_mask(4, 11));
        run_op("R9 insert wrapped", 2'b10, {2{64'h0123_4567_89AB_CDEF}}, mk_ctl(17, 90, 30),
               {4{32'hA5A5_5A5A}},
               (ref_rot({2{64'h0123_4567_89AB_CDEF}}, 17) & ref_mask(90, 30)) |
               ({4{32'hA5A5_5A5A}} & ~ref_mask(90, 30)));
    endtask

    task automatic t_random;
        for (int k = 0; k < 150; k++) begin
            logic [W-1:0] a = {$urandom, $urandom, $urandom, $urandom};
            logic [W-1:0] c = {$urandom, $urandom, $urandom, $urandom};
            logic [W-1:0] t = {$urandom, $urandom, $urandom, $urandom};
            logic [1:0]   op = 2'($urandom_range(0, 3));
            run_op("R2 R3 R5 R6 R7 R8 R9 random", op, a, c, t, ref_op(op, a, c, t));
        end
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_rotate();
        t_ignore();
        t_mask_contig();
        t_mask_wrap();
        t_insert();
        t_random();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=complete");
            finish_run();
        end
    end
endmodule